// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block carries 18-bit words from a producer on one clock to a consumer on a second, unrelated clock. The producer presents a word with an active-low enable and a direction bit that must be at its write setting. The consumer pulls words with its own active-low enable and receives each one in a registered output. An active-low output enable gates that output; a deasserted output enable forces the data to zero and drops a valid bit, which stands in for a high-impedance bus. The depth is a parameter, 256 or 512 entries.

Four active-low flags report fill level. Empty and almost-empty are registered on the read clock. Full and almost-full are registered on the write clock. Each side keeps a small state machine. The write side has the states `W_OPEN`, `W_NEAR` and `W_FULL`. The transition into `W_FULL` happens when a write brings the count to the depth, and the transition into `W_NEAR` happens when the count passes the almost-full threshold. The read side has the states `R_DRY`, `R_LOW` and `R_OK`. It moves to `R_DRY` when the count reaches zero, to `R_LOW` when the count is at or under the almost-empty offset, and to `R_OK` otherwise.

Pointers cross between the clocks as Gray codes through two-stage synchronizers. A flag therefore goes active in the cycle after the operation that causes it. It can release up to about two cycles of the other clock late. Each offset register has a parallel value input and a load strobe in the clock domain of the flag that uses it.

Top module: `dcf_fifo`

## Requirements
- R1: Words leave in the order they were accepted, with all 18 bits intact.
- R2: A word is accepted only on a rising `wr_clk` edge where `wr_en_n` is 0 and `wr_dir` is 0. With `wr_dir` at 1 the port is not writing and nothing is stored.
- R3: A word is removed only on a rising `rd_clk` edge with `rd_en_n` at 0. It appears on `rd_data` after that edge.
- R4: `empty_n` is 0 whenever no word is stored. A read attempted while `empty_n` is 0 is ignored, and `rd_data` and the read position are kept.
- R5: `full_n` is 0 when DEPTH words are stored. A write attempted while `full_n` is 0 is ignored and stores nothing.
- R6: `aempty_n` is 0 exactly when the stored count is less than or equal to the almost-empty offset. The value is judged once both pointers have crossed.
- R7: `afull_n` is 0 exactly when the stored count is greater than DEPTH minus the almost-full offset. The value is judged once both pointers have crossed.
- R8: After reset both offsets are 8. `ae_ld` on a `rd_clk` edge loads `ae_val`, and `af_ld` on a `wr_clk` edge loads `af_val`.
- R9: While `rd_oe_n` is 1, `rd_valid` is 0 and `rd_data` is 0. While `rd_oe_n` is 0, `rd_valid` is 1.
- R10: Reset (`rst_n` at 0) empties the FIFO and sets the flags as follows: `empty_n` 0, `aempty_n` 0, `full_n` 1, `afull_n` 1. The output register is cleared to 0.
- R11: `full_n` goes to 0 right after the write edge that fills the last entry. `empty_n` goes to 0 right after the read edge that removes the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset of both sides |
| wr_en_n | input | 1 | Active-low write enable |
| wr_dir | input | 1 | Write direction, 0 = write |
| wr_data | input | 18 | Word to store |
| af_ld | input | 1 | Load strobe for the almost-full offset (wr_clk) |
| af_val | input | AW+1 | New almost-full offset |
| full_n | output | 1 | Active-low full flag (wr_clk) |
| afull_n | output | 1 | Active-low almost-full flag (wr_clk) |
| rd_en_n | input | 1 | Active-low read enable |
| rd_oe_n | input | 1 | Active-low output enable |
| ae_ld | input | 1 | Load strobe for the almost-empty offset (rd_clk) |
| ae_val | input | AW+1 | New almost-empty offset |
| rd_data | output | 18 | Registered read word, 0 while disabled |
| rd_valid | output | 1 | High while the output is driven |
| empty_n | output | 1 | Active-low empty flag (rd_clk) |
| aempty_n | output | 1 | Active-low almost-empty flag (rd_clk) |

## Verification
A write and a read can fall in the same stretch of time while the count sits at a boundary. Each side then sees the other's pointer only after synchronization, so a full or empty flag can be stale by design. The bench provokes this with random concurrent traffic on two clocks of unrelated period. A shared scoreboard judges it: a word is pushed only when the write side's flag allowed it, and popped only when the read side's flag allowed it. Every returned word must match. Flag levels are then judged after a quiet interval against the scoreboard count.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    localparam int WORD_W = 18;

    typedef enum logic [1:0] {
        W_OPEN = 2'd0,
        W_NEAR = 2'd1,
        W_FULL = 2'd2
    } wr_state_e;

    typedef enum logic [1:0] {
        R_DRY = 2'd0,
        R_LOW = 2'd1,
        R_OK  = 2'd2
    } rd_state_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int DEPTH = 256,
    parameter int DW    = 18,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          wen,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          ren,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wen) begin
            store[waddr] <= wdata;
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (ren) begin
            rdata <= store[raddr];
        end
    end
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_n,
    input  logic          dir,
    input  logic          off_ld,
    input  logic [PW-1:0] off_val,
    input  logic [PW-1:0] rgray_s,
    output logic          wen,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic [PW-1:0] wbin,
    output logic [PW-1:0] off,
    output logic          full_n,
    output logic          afull_n
);
    wr_state_e     state_q, state_d;
    logic [PW-1:0] wbin_d, rbin_s, used_d;
    logic [PW:0]   reach;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    assign wen    = !en_n && !dir && (state_q != W_FULL);
    assign wbin_d = wbin + PW'(wen);
    assign rbin_s = g2b(rgray_s);
    assign used_d = wbin_d - rbin_s;
    assign reach  = {1'b0, used_d} + {1'b0, off};
    assign waddr  = wbin[AW-1:0];

    always_comb begin
        if (used_d == PW'(DEPTH)) begin
            state_d = W_FULL;
        end else if (reach > (PW+1)'(DEPTH)) begin
            state_d = W_NEAR;
        end else begin
            state_d = W_OPEN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W_OPEN;
            wbin    <= '0;
            wgray   <= '0;
            off     <= PW'(8);
        end else begin
            state_q <= state_d;
            wbin    <= wbin_d;
            wgray   <= wbin_d ^ (wbin_d >> 1);
            if (off_ld) begin
                off <= off_val;
            end
        end
    end

    always_comb begin
        full_n  = 1'b1;
        afull_n = 1'b1;
        unique case (state_q)
            W_OPEN: ;
            W_NEAR: afull_n = 1'b0;
            W_FULL: begin
                full_n  = 1'b0;
                afull_n = (off == '0);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_n,
    input  logic          off_ld,
    input  logic [PW-1:0] off_val,
    input  logic [PW-1:0] wgray_s,
    output logic          ren,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic [PW-1:0] rbin,
    output logic          empty_n,
    output logic          aempty_n
);
    rd_state_e     state_q, state_d;
    logic [PW-1:0] rbin_d, wbin_s, used_d, off;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    assign ren    = !en_n && (state_q != R_DRY);
    assign rbin_d = rbin + PW'(ren);
    assign wbin_s = g2b(wgray_s);
    assign used_d = wbin_s - rbin_d;
    assign raddr  = rbin[AW-1:0];

    always_comb begin
        if (used_d == '0) begin
            state_d = R_DRY;
        end else if (used_d <= off) begin
            state_d = R_LOW;
        end else begin
            state_d = R_OK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= R_DRY;
            rbin    <= '0;
            rgray   <= '0;
            off     <= PW'(8);
        end else begin
            state_q <= state_d;
            rbin    <= rbin_d;
            rgray   <= rbin_d ^ (rbin_d >> 1);
            if (off_ld) begin
                off <= off_val;
            end
        end
    end

    always_comb begin
        empty_n  = 1'b1;
        aempty_n = 1'b1;
        unique case (state_q)
            R_DRY: begin
                empty_n  = 1'b0;
                aempty_n = 1'b0;
            end
            R_LOW: aempty_n = 1'b0;
            R_OK:  ;
            default: ;
        endcase
    end
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
    import dcf_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_en_n,
    input  logic              wr_dir,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              af_ld,
    input  logic [PW-1:0]     af_val,
    output logic              full_n,
    output logic              afull_n,
    input  logic              rd_en_n,
    input  logic              rd_oe_n,
    input  logic              ae_ld,
    input  logic [PW-1:0]     ae_val,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              empty_n,
    output logic              aempty_n
);
    logic              wen, ren;
    logic [AW-1:0]     waddr, raddr;
    logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
    logic [PW-1:0]     w_ptr, r_ptr, af_off;
    logic [WORD_W-1:0] rd_q;

    dcf_wr_side #(.DEPTH(DEPTH)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .en_n(wr_en_n), .dir(wr_dir),
        .off_ld(af_ld), .off_val(af_val), .rgray_s(rgray_s),
        .wen(wen), .waddr(waddr), .wgray(wgray), .wbin(w_ptr),
        .off(af_off), .full_n(full_n), .afull_n(afull_n)
    );

    dcf_rd_side #(.DEPTH(DEPTH)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .en_n(rd_en_n),
        .off_ld(ae_ld), .off_val(ae_val), .wgray_s(wgray_s),
        .ren(ren), .raddr(raddr), .rgray(rgray), .rbin(r_ptr),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    dcf_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
    dcf_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

    dcf_mem #(.DEPTH(DEPTH), .DW(WORD_W)) u_mem (
        .wr_clk(wr_clk), .wen(wen), .waddr(waddr), .wdata(wr_data),
        .rd_clk(rd_clk), .rst_n(rst_n), .ren(ren), .raddr(raddr), .rdata(rd_q)
    );

    assign rd_valid = !rd_oe_n;
    assign rd_data  = rd_oe_n ? '0 : rd_q;
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
    parameter int PW = 9
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          wr_en_n,
    input logic          wr_dir,
    input logic          rd_en_n,
    input logic          rd_oe_n,
    input logic          full_n,
    input logic          afull_n,
    input logic          empty_n,
    input logic          aempty_n,
    input logic          rd_valid,
    input logic [17:0]   rd_data,
    input logic [PW-1:0] w_ptr,
    input logic [PW-1:0] r_ptr,
    input logic [PW-1:0] af_off
);
    p_dir_hold_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_en_n || wr_dir) |=> $stable(w_ptr));

    p_rd_idle_r3: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_en_n |=> $stable(r_ptr));

    p_no_underflow_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!empty_n && !rd_en_n) |=> $stable(r_ptr));

    p_no_overflow_r5: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!full_n && !wr_en_n && !wr_dir) |=> $stable(w_ptr));

    p_dry_is_low_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);

    p_full_is_near_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!full_n && af_off != '0) |-> !afull_n);

    p_hiz_r9: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_oe_n |-> (!rd_valid && rd_data == '0));
endmodule

bind dcf_fifo dcf_checker #(.PW(PW)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_en_n(wr_en_n), .wr_dir(wr_dir), .rd_en_n(rd_en_n), .rd_oe_n(rd_oe_n),
    .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .w_ptr(w_ptr), .r_ptr(r_ptr), .af_off(af_off)
);

// File: tb/dcf_fifo_tb.sv
module dcf_fifo_tb;
    localparam int DEPTH = 256;
    localparam int PW    = $clog2(DEPTH) + 1;

    logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
    logic wr_en_n = 1'b1, wr_dir = 1'b0, af_ld = 1'b0, ae_ld = 1'b0;
    logic rd_en_n = 1'b1, rd_oe_n = 1'b0;
    logic [17:0] wr_data = '0;
    logic [PW-1:0] af_val = '0, ae_val = '0;
    logic full_n, afull_n, empty_n, aempty_n, rd_valid;
    logic [17:0] rd_data;

    int checks = 0, errors = 0;
    int ae_v = 8, af_v = 8;
    logic [17:0] sb[$];
    bit done = 0;

    always #2.5 wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    dcf_fifo #(.DEPTH(DEPTH)) u_dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_en_n(wr_en_n), .wr_dir(wr_dir), .wr_data(wr_data),
        .af_ld(af_ld), .af_val(af_val), .full_n(full_n), .afull_n(afull_n),
        .rd_en_n(rd_en_n), .rd_oe_n(rd_oe_n), .ae_ld(ae_ld), .ae_val(ae_val),
        .rd_data(rd_data), .rd_valid(rd_valid), .empty_n(empty_n), .aempty_n(aempty_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_ae(input int cnt, input int off);
        return cnt <= off;
    endfunction

    function automatic bit exp_af(input int cnt, input int off);
        return cnt > DEPTH - off;
    endfunction

    task automatic wr_word(input logic [17:0] d, input bit dir);
        bit take;
        @(negedge wr_clk);
        wr_en_n = 1'b0; wr_dir = dir; wr_data = d;
        take = full_n && !dir;
        @(posedge wr_clk);
        if (take) sb.push_back(d);
        @(negedge wr_clk);
        wr_en_n = 1'b1; wr_dir = 1'b0;
    endtask

    task automatic rd_word();
        bit take;
        logic [17:0] e;
        @(negedge rd_clk);
        rd_en_n = 1'b0;
        take = empty_n;
        @(posedge rd_clk);
        @(negedge rd_clk);
        rd_en_n = 1'b1;
        if (take) begin
            e = sb.pop_front();
            check(rd_data === e, "R1/R3 data order", int'(rd_data), int'(e));
        end
    endtask

    task automatic settle();
        wr_en_n = 1'b1; rd_en_n = 1'b1;
        repeat (12) @(negedge rd_clk);
        repeat (12) @(negedge wr_clk);
    endtask

    task automatic flag_check(input string tag);
        int n;
        n = sb.size();
        check(empty_n == (n != 0), {tag, " R4 empty_n"}, empty_n, n != 0);
        check(full_n == (n != DEPTH), {tag, " R5 full_n"}, full_n, n != DEPTH);
        check(aempty_n == !exp_ae(n, ae_v), {tag, " R6 aempty_n"}, aempty_n, !exp_ae(n, ae_v));
        check(afull_n == !exp_af(n, af_v), {tag, " R7 afull_n"}, afull_n, !exp_af(n, af_v));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [17:0] hold;
        void'($urandom(32'd4242));
        #20 rst_n = 1'b1;
        repeat (3) @(negedge rd_clk);
        // R10: reset state
        check(empty_n == 0 && aempty_n == 0, "R10 read flags", {empty_n, aempty_n}, 0);
        check(full_n == 1 && afull_n == 1, "R10 write flags", {full_n, afull_n}, 3);
        check(rd_data == 0 && rd_valid == 1, "R10 output", int'(rd_data), 0);

        // R2: direction high stores nothing
        wr_word(18'h155AA, 1'b1);
        settle();
        check(empty_n == 0, "R2 dir-high ignored", empty_n, 0);

        // R6/R8: default almost-empty offset 8
        for (int i = 0; i < 8; i++) wr_word(18'(i + 18'h100), 1'b0);
        settle();
        check(aempty_n == 0, "R6 R8 count 8 at default", aempty_n, 0);
        wr_word(18'h3F0F0, 1'b0);
        settle();
        check(aempty_n == 1, "R6 R8 count 9 at default", aempty_n, 1);

        // R7/R8: default almost-full offset 8
        while (sb.size() < DEPTH - 8) wr_word(18'($urandom), 1'b0);
        settle();
        flag_check("count DEPTH-8");
        check(afull_n == 1, "R7 R8 at DEPTH-8", afull_n, 1);
        wr_word(18'h2AAAA, 1'b0);
        settle();
        check(afull_n == 0, "R7 R8 at DEPTH-7", afull_n, 0);

        // R11/R5: fill to the last entry
        while (sb.size() < DEPTH - 1) wr_word(18'($urandom), 1'b0);
        settle();
        wr_word(18'h0BEEF, 1'b0);
        check(full_n == 0, "R11 full right after filling write", full_n, 0);
        wr_word(18'h3DEAD, 1'b0);
        settle();
        check(sb.size() == DEPTH, "R5 overflow write ignored", sb.size(), DEPTH);
        flag_check("full");

        // R9: output enable high
        @(negedge rd_clk); rd_oe_n = 1'b1; #1;
        check(rd_valid == 0 && rd_data == 0, "R9 disabled output", int'(rd_data), 0);
        @(negedge rd_clk); rd_oe_n = 1'b0;

        // R1/R3/R11: drain everything
        while (sb.size() > 1) rd_word();
        settle();
        rd_word();
        check(empty_n == 0, "R11 empty right after last read", empty_n, 0);
        hold = rd_data;
        rd_word();
        settle();
        check(rd_data == hold, "R4 read on empty keeps data", int'(rd_data), int'(hold));
        flag_check("drained");
        wr_word(18'h12345, 1'b0);
        settle();
        rd_word();

        // R8: load new offsets
        @(negedge wr_clk); af_ld = 1'b1; af_val = PW'(30);
        @(negedge wr_clk); af_ld = 1'b0; af_v = 30;
        @(negedge rd_clk); ae_ld = 1'b1; ae_val = PW'(20);
        @(negedge rd_clk); ae_ld = 1'b0; ae_v = 20;
        for (int i = 0; i < 20; i++) wr_word(18'($urandom), 1'b0);
        settle();
        check(aempty_n == 0, "R8 loaded ae offset, count 20", aempty_n, 0);
        wr_word(18'h00777, 1'b0);
        settle();
        check(aempty_n == 1, "R8 loaded ae offset, count 21", aempty_n, 1);

        // Random concurrent traffic
        for (int round = 0; round < 4; round++) begin
            fork
                begin
                    for (int k = 0; k < 700; k++) begin
                        if ($urandom % 4 != 0) wr_word(18'($urandom), ($urandom % 9) == 0);
                        else @(negedge wr_clk);
                    end
                end
                begin
                    for (int k = 0; k < 500; k++) begin
                        if ($urandom % 3 != 0) rd_word();
                        else @(negedge rd_clk);
                    end
                end
            join
            settle();
            flag_check("random");
        end
        while (sb.size() > 0) rd_word();
        settle();
        flag_check("final");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule